// File: doc/BRIEF.md
# Byte-Granular 2D Fill and Copy Engine

This block runs rectangle operations on a linear, byte-addressed framebuffer. Software programs source and destination corners, a width and height, the row pitch of each surface, each surface's base address and a foreground byte through a word-indexed register port. It then writes the control word with the start bit set. The engine either paints the rectangle with the foreground byte or copies a rectangle from one place to another, one byte at a time, through a single-port memory interface. The memory returns read data one cycle after a read request.

Every horizontal quantity is a byte count, so a pixel of several bytes spans several columns. A copy can overlap its own source. Software picks the walk direction: when the source row lies above the destination row, or the rows are equal and the source lies further left, it sets the reverse bit. It also loads both corner registers with the bottom-right byte (position plus dimension minus one). A status bit shows when the engine is working.

Top module: `blit_engine`

## Requirements
- R1: After reset the busy output and status bit 3 are 0, and neither memory enable is asserted.
- R2: A start with command field (control bits 19:16) equal to 1 fills every byte at dstBase + y*dstPitch + x of the rectangle with the low byte of the foreground register. It writes one byte per cycle, row by row, beginning at the destination corner.
- R3: A start with command 0 copies the rectangle. Each byte is read at srcBase + y*srcPitch + x, and the cycle after the read it is written to the matching destination byte. A copy therefore takes two cycles per byte.
- R4: With control bit 27 set, the walk begins at the programmed corners and descends in x within a row, then in y. The first write goes to the programmed destination corner.
- R5: Overlapping copies give the same result as copying from an unmodified snapshot of the source, both in reverse mode (source above) and in forward mode (source below).
- R6: Control bit 31 starts an operation. Busy rises on the cycle after the start write and stays high for exactly one cycle per filled byte, or two per copied byte. Status bit 3 (register 1) mirrors busy.
- R7: While busy, every register write is ignored, including a second start and changes to the configuration registers. Those registers read back unchanged afterwards.
- R8: A start with width (DIM bits 31:16) or height (DIM bits 15:0) equal to zero makes no memory access and never sets busy.
- R9: A start whose command field is neither 0 nor 1 is ignored.
- R10: The engine never asserts read and write in the same cycle, and asserts neither while idle.
- R11: The register map is as follows. 0 holds control (bit 31 start, which reads as 0; bit 27 reverse; bits 19:16 command). 1 holds status. 2 is the source corner and 3 the destination corner, each with x in bits 31:16 and y in bits 15:0. 4 holds the dimensions. 5 holds the pitches (source in bits 15:0, destination in bits 31:16). 6 holds the foreground byte. 7 is the source base and 8 the destination base. All of them read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| busy | output | 1 | Operation in progress |
| memAddr | output | ADDR_W | Byte address to memory |
| memWe | output | 1 | Memory write enable |
| memRe | output | 1 | Memory read enable |
| memWrData | output | 8 | Memory write byte |
| memRdData | input | 8 | Memory read byte, valid the cycle after memRe |

## Verification
The hardest case to reach is a copy whose source and destination overlap. A wrong walk order does not stand out there: it quietly reads bytes the same operation has already overwritten. The bench fills memory with an address-derived pattern and runs overlapping copies in both directions within one surface. It then compares every byte against a result it builds from a snapshot taken before the operation. A second hard case is a start arriving while an operation runs. The bench issues a conflicting start and a foreground change one cycle into a fill. It then checks the byte count, the painted value and the foreground readback.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int REG_CTRL   = 0;
  localparam int REG_STATUS = 1;
  localparam int REG_SRC    = 2;
  localparam int REG_DST    = 3;
  localparam int REG_DIM    = 4;
  localparam int REG_PITCH  = 5;
  localparam int REG_FG     = 6;
  localparam int REG_SBASE  = 7;
  localparam int REG_DBASE  = 8;

  localparam int START_BIT  = 31;
  localparam int REV_BIT    = 27;
  localparam int CMD_LSB    = 16;
  localparam int BUSY_BIT   = 3;

  localparam logic [3:0] CMD_COPY = 4'd0;
  localparam logic [3:0] CMD_FILL = 4'd1;

  typedef struct packed {
    logic load;    // capture working counters at start
    logic step;    // advance to the next byte
    logic selDst;  // memory address from destination walker
    logic useFg;   // write data from foreground register
  } blitStrobe_t;
endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic              dimZero,
  input  logic              lastPix,
  output blitStrobe_t       strb,
  output logic              busy,
  output logic              memWe,
  output logic              memRe
);
  typedef enum logic [1:0] {S_IDLE, S_FILL, S_READ, S_WRITE} state_t;
  state_t state, stateNext;

  logic [3:0] cmd;
  logic goReq;

  assign cmd   = regWrData[CMD_LSB +: 4];
  assign goReq = regWrEn && (regAddr == REG_AW'(REG_CTRL)) && regWrData[START_BIT]
                 && (state == S_IDLE) && !dimZero
                 && ((cmd == CMD_FILL) || (cmd == CMD_COPY));

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (goReq) stateNext = (cmd == CMD_FILL) ? S_FILL : S_READ;
      S_FILL:  if (lastPix) stateNext = S_IDLE;
      S_READ:  stateNext = S_WRITE;
      S_WRITE: stateNext = lastPix ? S_IDLE : S_READ;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign busy        = (state != S_IDLE);
  assign memWe       = (state == S_FILL) || (state == S_WRITE);
  assign memRe       = (state == S_READ);
  assign strb.load   = goReq;
  assign strb.step   = memWe;
  assign strb.selDst = memWe;
  assign strb.useFg  = (state == S_FILL);
endmodule

// File: rtl/blit_path.sv
module blit_path
  import blit_pkg::*;
#(
  parameter int REG_AW  = 4,
  parameter int ADDR_W  = 20,
  parameter int COORD_W = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  blitStrobe_t       strb,
  input  logic              busy,
  input  logic [DATA_W-1:0] memRdData,
  output logic [31:0]       regRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              dimZero,
  output logic              lastPix
);
  localparam int PROD_W = 2 * COORD_W;
  localparam int SUM_W  = (PROD_W > ADDR_W) ? PROD_W : ADDR_W;

  logic [COORD_W-1:0] srcX, srcY, dstX, dstY, dimW, dimH, srcPitch, dstPitch;
  logic [DATA_W-1:0]  fgColor;
  logic [ADDR_W-1:0]  srcBase, dstBase;
  logic [3:0]         cmdReg;
  logic               revReg;

  logic [COORD_W-1:0] wSx, wSy, wDx, wDy, colLeft, rowLeft;
  logic               wRev;
  logic               cfgWr;

  assign cfgWr = regWrEn && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcX <= '0; srcY <= '0; dstX <= '0; dstY <= '0;
      dimW <= '0; dimH <= '0; srcPitch <= '0; dstPitch <= '0;
      fgColor <= '0; srcBase <= '0; dstBase <= '0;
      cmdReg <= '0; revReg <= 1'b0;
    end else if (cfgWr) begin
      case (regAddr)
        REG_AW'(REG_CTRL):  begin
          cmdReg <= regWrData[CMD_LSB +: 4];
          revReg <= regWrData[REV_BIT];
        end
        REG_AW'(REG_SRC):   {srcX, srcY} <= {regWrData[31:16], regWrData[15:0]};
        REG_AW'(REG_DST):   {dstX, dstY} <= {regWrData[31:16], regWrData[15:0]};
        REG_AW'(REG_DIM):   {dimW, dimH} <= {regWrData[31:16], regWrData[15:0]};
        REG_AW'(REG_PITCH): {dstPitch, srcPitch} <= {regWrData[31:16], regWrData[15:0]};
        REG_AW'(REG_FG):    fgColor <= regWrData[DATA_W-1:0];
        REG_AW'(REG_SBASE): srcBase <= regWrData[ADDR_W-1:0];
        REG_AW'(REG_DBASE): dstBase <= regWrData[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  logic lastCol;
  assign lastCol = (colLeft == COORD_W'(1));
  assign lastPix = lastCol && (rowLeft == COORD_W'(1));
  assign dimZero = (dimW == '0) || (dimH == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wSx <= '0; wSy <= '0; wDx <= '0; wDy <= '0;
      colLeft <= '0; rowLeft <= '0; wRev <= 1'b0;
    end else if (strb.load) begin
      wSx <= srcX; wSy <= srcY; wDx <= dstX; wDy <= dstY;
      colLeft <= dimW; rowLeft <= dimH;
      wRev <= regWrData[REV_BIT];
    end else if (strb.step) begin
      if (lastCol) begin
        if (!lastPix) begin
          rowLeft <= rowLeft - 1'b1;
          colLeft <= dimW;
          wSx <= srcX;
          wDx <= dstX;
          wSy <= wRev ? wSy - 1'b1 : wSy + 1'b1;
          wDy <= wRev ? wDy - 1'b1 : wDy + 1'b1;
        end
      end else begin
        colLeft <= colLeft - 1'b1;
        wSx <= wRev ? wSx - 1'b1 : wSx + 1'b1;
        wDx <= wRev ? wDx - 1'b1 : wDx + 1'b1;
      end
    end
  end

  logic [SUM_W-1:0] srcSum, dstSum;
  assign srcSum = SUM_W'(srcBase) + SUM_W'(PROD_W'(wSy) * PROD_W'(srcPitch)) + SUM_W'(wSx);
  assign dstSum = SUM_W'(dstBase) + SUM_W'(PROD_W'(wDy) * PROD_W'(dstPitch)) + SUM_W'(wDx);

  assign memAddr   = strb.selDst ? dstSum[ADDR_W-1:0] : srcSum[ADDR_W-1:0];
  assign memWrData = strb.useFg ? fgColor : memRdData;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_AW'(REG_CTRL):   begin
        regRdData[REV_BIT] = revReg;
        regRdData[CMD_LSB +: 4] = cmdReg;
      end
      REG_AW'(REG_STATUS): regRdData[BUSY_BIT] = busy;
      REG_AW'(REG_SRC):    regRdData = {srcX, srcY};
      REG_AW'(REG_DST):    regRdData = {dstX, dstY};
      REG_AW'(REG_DIM):    regRdData = {dimW, dimH};
      REG_AW'(REG_PITCH):  regRdData = {dstPitch, srcPitch};
      REG_AW'(REG_FG):     regRdData[DATA_W-1:0] = fgColor;
      REG_AW'(REG_SBASE):  regRdData[ADDR_W-1:0] = srcBase;
      REG_AW'(REG_DBASE):  regRdData[ADDR_W-1:0] = dstBase;
      default: ;
    endcase
  end
endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              busy,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData
);
  blitStrobe_t strb;
  logic dimZero, lastPix;

  blit_ctrl #(.REG_AW(REG_AW)) ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .dimZero(dimZero), .lastPix(lastPix),
    .strb(strb), .busy(busy), .memWe(memWe), .memRe(memRe)
  );

  blit_path #(.REG_AW(REG_AW), .ADDR_W(ADDR_W), .COORD_W(16), .DATA_W(8)) path (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strb(strb), .busy(busy), .memRdData(memRdData),
    .regRdData(regRdData), .memAddr(memAddr), .memWrData(memWrData),
    .dimZero(dimZero), .lastPix(lastPix)
  );
endmodule

// File: rtl/blit_engine_check.sv
module blit_engine_check #(
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic [31:0]       regRdData,
  input logic              busy,
  input logic              memWe,
  input logic              memRe
);
  logic [31:0] dimShadow;
  always_ff @(posedge clk) begin
    if (!rstN) dimShadow <= '0;
    else if (regWrEn && !busy && regAddr == REG_AW'(4)) dimShadow <= regWrData;
  end

  logic startIdle, cmdOk, dimsOk;
  assign startIdle = regWrEn && !busy && (regAddr == REG_AW'(0)) && regWrData[31];
  assign cmdOk     = (regWrData[19:16] == 4'd0) || (regWrData[19:16] == 4'd1);
  assign dimsOk    = (dimShadow[31:16] != 16'd0) && (dimShadow[15:0] != 16'd0);

  a_r10_no_dual_access: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));
  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memWe && !memRe));
  a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> memWe);
  a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (startIdle && cmdOk && dimsOk) |=> busy);
  a_r8_zero_dim_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (startIdle && !dimsOk) |=> !busy);
  a_r9_bad_cmd_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (startIdle && !cmdOk) |=> !busy);
  a_r6_status_mirrors_busy: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_AW'(1)) |-> (regRdData[3] == busy));
endmodule

bind blit_engine blit_engine_check #(.REG_AW(REG_AW)) chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .busy(busy),
  .memWe(memWe), .memRe(memRe)
);

// File: tb/blit_engine_test.sv
`timescale 1ns/1ps
module blit_engine_test;
  localparam int REG_AW = 4;
  localparam int ADDR_W = 20;
  localparam int MEM_N  = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [REG_AW-1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic busy;
  logic [ADDR_W-1:0] memAddr;
  logic memWe, memRe;
  logic [7:0] memWrData;
  logic [7:0] memRdData = '0;

  always #2 clk = ~clk;

  blit_engine #(.REG_AW(REG_AW), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe),
    .memWrData(memWrData), .memRdData(memRdData)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'(a >> 4) ^ 8'h3C;
  endfunction

  logic [7:0] mem [MEM_N];
  logic [7:0] expm [MEM_N];
  int wrCnt = 0, rdCnt = 0, busyCnt = 0, badCnt = 0;
  int wrMark = 0;
  int firstWr = -1;
  int errors = 0, checks = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= pat(i);
    end else begin
      if (memWe) begin
        mem[int'(memAddr) % MEM_N] <= memWrData;
        if (wrCnt == wrMark) firstWr <= int'(memAddr);
        wrCnt <= wrCnt + 1;
      end
      if (memRe) begin
        memRdData <= mem[int'(memAddr) % MEM_N];
        rdCnt <= rdCnt + 1;
      end
      if (busy) busyCnt <= busyCnt + 1;
      if ((memWe && memRe) || ((memWe || memRe) && !busy)) badCnt <= badCnt + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic regWr(input int a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = REG_AW'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRd(input int a, output logic [31:0] d);
    @(negedge clk);
    regAddr = REG_AW'(a);
    #1 d = regRdData;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compareMem(input string tag);
    int bad = 0, firstBad = -1;
    for (int i = 0; i < MEM_N; i++)
      if (mem[i] !== expm[i]) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
    if (firstBad >= 0) chk({tag, " byte@", $sformatf("%0h", firstBad)}, mem[firstBad], expm[firstBad]);
    else chk({tag, " memory image"}, 0, 0);
  endtask

  task automatic setup(input int sx, sy, dx, dy, w, h, sp, dp, fg, sb, db);
    regWr(2, {16'(sx), 16'(sy)});
    regWr(3, {16'(dx), 16'(dy)});
    regWr(4, {16'(w), 16'(h)});
    regWr(5, {16'(dp), 16'(sp)});
    regWr(6, 32'(fg));
    regWr(7, 32'(sb));
    regWr(8, 32'(db));
  endtask

  task automatic expFill(input int x, y, w, h, p, b, fg);
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++) expm[b + (y + j) * p + x + i] = 8'(fg);
  endtask

  task automatic expCopy(input int sx, sy, dx, dy, w, h, sp, dp, sb, db);
    logic [7:0] snap [MEM_N];
    for (int i = 0; i < MEM_N; i++) snap[i] = expm[i];
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++)
        expm[db + (dy + j) * dp + dx + i] = snap[sb + (sy + j) * sp + sx + i];
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R1 busy after reset", busy, 0);
    chk("R1 memWe after reset", memWe, 0);
    chk("R1 memRe after reset", memRe, 0);
    regRd(1, d);
    chk("R1 status after reset", d, 0);
  endtask

  task automatic testReadback();
    logic [31:0] d;
    setup(3, 4, 5, 6, 7, 8, 16, 32, 8'hA5, 20'h100, 20'h280);
    regWr(0, 32'h0802_0000);
    regRd(0, d); chk("R11 ctrl readback", d, 32'h0802_0000);
    regRd(2, d); chk("R11 src readback", d, 32'h0003_0004);
    regRd(4, d); chk("R11 dim readback", d, 32'h0007_0008);
    regRd(5, d); chk("R11 pitch readback", d, 32'h0020_0010);
    regRd(8, d); chk("R11 dst base readback", d, 32'h280);
  endtask

  task automatic testFill();
    int w0, b0, r0;
    logic [31:0] d;
    setup(0, 0, 2, 1, 5, 3, 16, 16, 8'hA5, 0, 20'h100);
    w0 = wrCnt; b0 = busyCnt; r0 = rdCnt; wrMark = wrCnt;
    regWr(0, 32'h8001_0000);
    regRd(1, d); chk("R6 status busy during fill", int'(d[3]), 1);
    waitIdle();
    expFill(2, 1, 5, 3, 16, 20'h100, 8'hA5);
    compareMem("R2 fill");
    chk("R2 fill write count", wrCnt - w0, 15);
    chk("R2 fill no reads", rdCnt - r0, 0);
    chk("R2 fill first address", firstWr, 20'h100 + 16 + 2);
    chk("R6 fill busy cycles", busyCnt - b0, 15);
    regRd(1, d); chk("R6 status idle after fill", int'(d[3]), 0);
  endtask

  task automatic testCopyFwd();
    int w0, b0, r0;
    setup(1, 0, 3, 2, 4, 3, 16, 32, 0, 20'h200, 20'h300);
    w0 = wrCnt; b0 = busyCnt; r0 = rdCnt; wrMark = wrCnt;
    regWr(0, 32'h8000_0000);
    waitIdle();
    expCopy(1, 0, 3, 2, 4, 3, 16, 32, 20'h200, 20'h300);
    compareMem("R3 copy");
    chk("R3 copy reads", rdCnt - r0, 12);
    chk("R3 copy writes", wrCnt - w0, 12);
    chk("R3 copy first address", firstWr, 20'h300 + 2 * 32 + 3);
    chk("R6 copy busy cycles", busyCnt - b0, 24);
  endtask

  task automatic testCopyRev();
    wrMark = wrCnt;
    setup(1 + 6 - 1, 1 + 4 - 1, 3 + 6 - 1, 2 + 4 - 1, 6, 4, 16, 16, 0, 20'h400, 20'h400);
    regWr(0, 32'h8800_0000);
    waitIdle();
    expCopy(1, 1, 3, 2, 6, 4, 16, 16, 20'h400, 20'h400);
    compareMem("R5 reverse overlap copy");
    chk("R4 reverse first write", firstWr, 20'h400 + 5 * 16 + 8);
  endtask

  task automatic testCopyFwdOverlap();
    setup(3, 2, 1, 1, 6, 4, 16, 16, 0, 20'h500, 20'h500);
    regWr(0, 32'h8000_0000);
    waitIdle();
    expCopy(3, 2, 1, 1, 6, 4, 16, 16, 20'h500, 20'h500);
    compareMem("R5 forward overlap copy");
  endtask

  task automatic testBusyIgnore();
    int w0, b0;
    logic [31:0] d;
    setup(0, 0, 0, 0, 8, 2, 16, 16, 8'h5A, 0, 20'h600);
    w0 = wrCnt; b0 = busyCnt;
    regWr(0, 32'h8001_0000);
    regWr(0, 32'h8000_0000);
    regWr(6, 32'h11);
    waitIdle();
    expFill(0, 0, 8, 2, 16, 20'h600, 8'h5A);
    compareMem("R7 fill unaffected by writes while busy");
    chk("R7 write count", wrCnt - w0, 16);
    chk("R7 busy cycles", busyCnt - b0, 16);
    regRd(6, d); chk("R7 fg unchanged", d, 32'h5A);
    regRd(0, d); chk("R7 ctrl unchanged", d, 32'h0001_0000);
  endtask

  task automatic testZeroDim();
    int w0, b0, r0;
    w0 = wrCnt; b0 = busyCnt; r0 = rdCnt;
    regWr(4, 32'h0000_0003);
    regWr(0, 32'h8001_0000);
    repeat (4) @(negedge clk);
    regWr(4, 32'h0004_0000);
    regWr(0, 32'h8000_0000);
    repeat (4) @(negedge clk);
    chk("R8 zero dim busy", busyCnt - b0, 0);
    chk("R8 zero dim writes", wrCnt - w0, 0);
    chk("R8 zero dim reads", rdCnt - r0, 0);
  endtask

  task automatic testBadCmd();
    int w0, b0, r0;
    w0 = wrCnt; b0 = busyCnt; r0 = rdCnt;
    regWr(4, 32'h0002_0002);
    regWr(0, 32'h8002_0000);
    repeat (4) @(negedge clk);
    chk("R9 bad cmd busy", busyCnt - b0, 0);
    chk("R9 bad cmd accesses", (wrCnt - w0) + (rdCnt - r0), 0);
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) expm[i] = pat(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadback();
    testFill();
    testCopyFwd();
    testCopyRev();
    testCopyFwdOverlap();
    testBusyIgnore();
    testZeroDim();
    testBadCmd();
    chk("R10 access protocol violations", badCnt, 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule